// File: doc/BRIEF.md
# Dual-Channel Bus-Master Register Block

This block holds the host-visible registers of a two-channel disk controller's bus-master I/O window, 16 bytes wide. Each channel owns an 8-byte slice. The lower half of a slice is a byte-only control area: command, the shared mode/interrupt register, status and a per-channel timing byte. The upper half is a 32-bit descriptor-table base pointer that accepts byte, word or dword writes.

The block also merges the two channel interrupt requests into one level-sensitive interrupt line. Each channel's request is gated by its own mask bit in the shared mode register. The DMA engine itself sits outside the block. It receives start and stop pulses, a direction bit and the table base from this block. It reports back an active level plus error and completion events.

Host accesses are single-cycle. A write is taken on the clock edge while `acc_wr` is high. Read data is combinational from the address and size.

Top module: `busmaster_regs`

## Requirements
- R1: After reset all registers read zero, `pci_irq` is low, and `dma_start`, `dma_stop` and `dma_dir` are low.
- R2: In the control area (byte offset bit 2 clear), only byte accesses (size code 0) have an effect. A word read (size 1) returns 0x0000FFFF and a dword read (size 2 or 3) returns 0xFFFFFFFF. Wider writes change nothing.
- R3: `acc_addr[3]` selects the channel. `acc_addr[2:0]` selects the register: 0 command, 1 mode, 2 status, 3 timing, and 4 to 7 the table base bytes (little-endian).
- R4: In the mode register, bits 2 and 3 hold the pending state of `ch_irq_in[0]` and `ch_irq_in[1]`, sampled each clock. Bits 4 and 5 mask channel 0 and channel 1. A byte write to offset 1 changes only bits 4 and 5. All other bits read zero.
- R5: `pci_irq` = (bit2 AND NOT bit4) OR (bit3 AND NOT bit5) of the mode register. It follows an input or a mask write in the cycle after the clock edge.
- R6: The status read value is bit 0 = the live `ch_dma_active` of that channel, bits 1, 2, 5 and 6 stored, and other bits zero. A status byte write loads bits 5 and 6 and clears bit 1 or bit 2 where the written bit is 1.
- R7: A `ch_err_evt` cycle sets status bit 1 and a `ch_done_evt` cycle sets status bit 2. A set wins over a clear on the same edge.
- R8: Offset 3 is a full 8-bit timing register, and each channel has its own.
- R9: A byte write to offset 0 latches bit 0 (run) and bit 3 (direction, driven on `dma_dir`). A 0-to-1 change of run pulses `dma_start` for one cycle, and a 1-to-0 change pulses `dma_stop`. A write that leaves run unchanged pulses neither. A read returns only bits 0 and 3.
- R10: The table base takes byte, word or dword writes. Byte lanes start at `acc_addr[1:0]`, and lanes beyond byte 3 are dropped. Bits 1:0 always read zero. A read returns the register shifted right by 8 times `acc_addr[1:0]`, masked to the access width.
- R11: Offset 1 of either channel reads and writes the same shared mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe, taken on the clock edge |
| acc_addr | input | 4 | Byte offset in the 16-byte window |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 or 3 dword |
| acc_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| acc_rdata | output | 32 | Read data for the addressed register |
| ch_irq_in | input | 2 | Per-channel interrupt request levels |
| ch_dma_active | input | 2 | Per-channel DMA-active levels |
| ch_err_evt | input | 2 | Per-channel error event, one cycle |
| ch_done_evt | input | 2 | Per-channel interrupt event, one cycle |
| dma_start | output | 2 | One-cycle start pulse per channel |
| dma_stop | output | 2 | One-cycle stop pulse per channel |
| dma_dir | output | 2 | Latched transfer direction per channel |
| prd_base | output | 64 | Table base pointers, channel 0 in bits 31:0 |
| pci_irq | output | 1 | Combined level interrupt |

## Verification
The assertions check on every cycle that:
- the interrupt line is low one cycle after both requests go low;
- the interrupt line stays low while both masks are set;
- a wide write into the control area leaves the timing bytes and masks untouched;
- a start pulse is always preceded by a byte write to a command offset;
- a table base holds its value unless its own byte range is written.

Only the bench scenarios can show the values:
- the lane placement of partial table writes;
- the write-one-to-clear and set-priority behaviour of the status bits;
- the run-edge detection of the command register;
- the mixing of pending and mask bits on a mode write.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

  localparam int NUM_CH   = 2;
  localparam int BYTE_W   = 8;
  localparam int TBL_B    = 4;
  localparam int TBL_W    = TBL_B * BYTE_W;
  localparam int ADDR_W   = 4;
  localparam int CH_BIT   = ADDR_W - 1;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_TIME = 2'd3
  } ctl_sel_e;

  typedef struct packed {
    logic       ch;
    logic       is_tbl;
    ctl_sel_e   sel;
    logic       byte_ok;
    logic [1:0] off;
    logic [3:0] lanes;
  } dec_t;

  // number of bytes an access touches, as a lane pattern at offset 0
  function automatic logic [3:0] size_pattern(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
    logic [6:0] wide;
    wide = {3'b000, size_pattern(sz)} << off;
    return wide[3:0];
  endfunction

  function automatic logic [TBL_W-1:0] ones_of(input logic [1:0] sz);
    logic [TBL_W-1:0] r;
    logic [3:0] p;
    p = size_pattern(sz);
    for (int k = 0; k < TBL_B; k++) r[k*BYTE_W +: BYTE_W] = {BYTE_W{p[k]}};
    return r;
  endfunction

  // stored status bits 6:1; bits 4:3 never hold anything
  function automatic logic [6:1] status_upd(input logic [6:1] old, input logic wr,
                                            input logic [7:0] w, input logic err,
                                            input logic done);
    logic [6:1] r;
    r = old;
    if (wr) begin
      r[6:5] = w[6:5];
      r[2:1] = old[2:1] & ~w[2:1];
    end
    r[1]   = r[1] | err;
    r[2]   = r[2] | done;
    r[4:3] = 2'b00;
    return r;
  endfunction

  function automatic logic [TBL_W-1:0] table_upd(input logic [TBL_W-1:0] old,
                                                 input logic [TBL_W-1:0] wsh,
                                                 input logic [3:0] lanes);
    logic [TBL_W-1:0] r;
    r = old;
    for (int k = 0; k < TBL_B; k++)
      if (lanes[k]) r[k*BYTE_W +: BYTE_W] = wsh[k*BYTE_W +: BYTE_W];
    r[1:0] = 2'b00;
    return r;
  endfunction

endpackage

// File: rtl/bmr_decode.sv
module bmr_decode
  import bmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output dec_t              dec
);
  always_comb begin
    dec.ch      = addr[CH_BIT];
    dec.is_tbl  = addr[2];
    dec.sel     = ctl_sel_e'(addr[1:0]);
    dec.byte_ok = (size == 2'd0);
    dec.off     = addr[1:0];
    dec.lanes   = addr[2] ? lane_mask(addr[1:0], size) : 4'b0000;
  end
endmodule

// File: rtl/bmr_channel.sv
module bmr_channel
  import bmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              wr_time,
  input  logic [3:0]        tbl_lanes,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [TBL_W-1:0]  wsh,
  input  logic              dma_active,
  input  logic              err_evt,
  input  logic              done_evt,
  output logic [BYTE_W-1:0] cmd_rd,
  output logic [BYTE_W-1:0] stat_rd,
  output logic [BYTE_W-1:0] time_rd,
  output logic [TBL_W-1:0]  tbl_q,
  output logic              start_o,
  output logic              stop_o,
  output logic              dir_o
);
  logic              run_q;
  logic              dir_q;
  logic [6:1]        stat_q;
  logic [BYTE_W-1:0] time_q;
  logic              start_q;
  logic              stop_q;
  logic              run_rise;
  logic              run_fall;

  assign run_rise = wr_cmd &  wbyte[0] & ~run_q;
  assign run_fall = wr_cmd & ~wbyte[0] &  run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= run_rise;
      stop_q  <= run_fall;
      if (wr_cmd) begin
        run_q <= wbyte[0];
        dir_q <= wbyte[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      time_q <= '0;
      tbl_q  <= '0;
    end else begin
      stat_q <= status_upd(stat_q, wr_stat, wbyte, err_evt, done_evt);
      if (wr_time) time_q <= wbyte;
      if (|tbl_lanes) tbl_q <= table_upd(tbl_q, wsh, tbl_lanes);
    end
  end

  assign cmd_rd  = {4'b0000, dir_q, 2'b00, run_q};
  assign stat_rd = {1'b0, stat_q, dma_active};
  assign time_rd = time_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/bmr_mode_irq.sv
module bmr_mode_irq
  import bmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [NUM_CH-1:0] irq_in,
  output logic [BYTE_W-1:0] mode_rd,
  output logic [NUM_CH-1:0] mask_q,
  output logic              irq_out
);
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= irq_in;
      if (wr_mode) mask_q <= wbyte[5:4];
    end
  end

  assign live    = pend_q & ~mask_q;
  assign irq_out = |live;
  assign mode_rd = {2'b00, mask_q, pend_q, 2'b00};
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import bmr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_wr,
  input  logic [3:0]              acc_addr,
  input  logic [1:0]              acc_size,
  input  logic [31:0]             acc_wdata,
  output logic [31:0]             acc_rdata,
  input  logic [1:0]              ch_irq_in,
  input  logic [1:0]              ch_dma_active,
  input  logic [1:0]              ch_err_evt,
  input  logic [1:0]              ch_done_evt,
  output logic [1:0]              dma_start,
  output logic [1:0]              dma_stop,
  output logic [1:0]              dma_dir,
  output logic [63:0]             prd_base,
  output logic                    pci_irq
);
  dec_t              dec;
  logic              ctl_byte_wr;
  logic              ctl_wide_wr;
  logic              wr_mode;
  logic [TBL_W-1:0]  wsh;
  logic [NUM_CH-1:0] mask_q;
  logic [BYTE_W-1:0] mode_rd;
  logic [BYTE_W-1:0] cmd_rd  [NUM_CH];
  logic [BYTE_W-1:0] stat_rd [NUM_CH];
  logic [BYTE_W-1:0] time_rd [NUM_CH];
  logic [TBL_W-1:0]  tbl_q   [NUM_CH];
  logic [NUM_CH*BYTE_W-1:0] timing_flat;

  bmr_decode i_dec (
    .addr (acc_addr),
    .size (acc_size),
    .dec  (dec)
  );

  assign ctl_byte_wr = acc_wr & ~dec.is_tbl &  dec.byte_ok;
  assign ctl_wide_wr = acc_wr & ~dec.is_tbl & ~dec.byte_ok;
  assign wr_mode     = ctl_byte_wr & (dec.sel == SEL_MODE);
  assign wsh         = acc_wdata << {dec.off, 3'b000};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic here;
    assign here = (dec.ch == c[0]);

    bmr_channel i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cmd     (ctl_byte_wr & here & (dec.sel == SEL_CMD)),
      .wr_stat    (ctl_byte_wr & here & (dec.sel == SEL_STAT)),
      .wr_time    (ctl_byte_wr & here & (dec.sel == SEL_TIME)),
      .tbl_lanes  ((acc_wr & here) ? dec.lanes : 4'b0000),
      .wbyte      (acc_wdata[BYTE_W-1:0]),
      .wsh        (wsh),
      .dma_active (ch_dma_active[c]),
      .err_evt    (ch_err_evt[c]),
      .done_evt   (ch_done_evt[c]),
      .cmd_rd     (cmd_rd[c]),
      .stat_rd    (stat_rd[c]),
      .time_rd    (time_rd[c]),
      .tbl_q      (tbl_q[c]),
      .start_o    (dma_start[c]),
      .stop_o     (dma_stop[c]),
      .dir_o      (dma_dir[c])
    );

    assign prd_base[c*TBL_W +: TBL_W]       = tbl_q[c];
    assign timing_flat[c*BYTE_W +: BYTE_W]  = time_rd[c];
  end

  bmr_mode_irq i_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mode (wr_mode),
    .wbyte   (acc_wdata[BYTE_W-1:0]),
    .irq_in  (ch_irq_in),
    .mode_rd (mode_rd),
    .mask_q  (mask_q),
    .irq_out (pci_irq)
  );

  always_comb begin
    logic [BYTE_W-1:0] b;
    case (dec.sel)
      SEL_CMD:  b = cmd_rd[dec.ch];
      SEL_MODE: b = mode_rd;
      SEL_STAT: b = stat_rd[dec.ch];
      default:  b = time_rd[dec.ch];
    endcase
    if (dec.is_tbl)
      acc_rdata = (tbl_q[dec.ch] >> {dec.off, 3'b000}) & ones_of(acc_size);
    else if (!dec.byte_ok)
      acc_rdata = ones_of(acc_size);
    else
      acc_rdata = {{(TBL_W-BYTE_W){1'b0}}, b};
  end
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_wr,
  input logic [3:0]  acc_addr,
  input logic [1:0]  acc_size,
  input logic [1:0]  ch_irq_in,
  input logic        pci_irq,
  input logic [1:0]  mask_q,
  input logic [15:0] timing_flat,
  input logic [1:0]  dma_start,
  input logic [63:0] prd_base,
  input logic        ctl_wide_wr
);
  // R5: no request pending -> line low after the next edge
  a_r5_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq_in == 2'b00) |=> !pci_irq);

  // R5: both masks set -> line low
  a_r5_masked_line: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 2'b11) |-> !pci_irq);

  // R2: wide control writes touch nothing
  a_r2_wide_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wide_wr |=> ($stable(timing_flat) && $stable(mask_q)));

  // R9: start pulse only after a byte write to a command offset
  a_r9_start_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_start != 2'b00) |->
      $past(acc_wr && acc_addr[2:0] == 3'd0 && acc_size == 2'd0));

  // R10: table base of channel 0 holds unless its bytes are written
  a_r10_table0_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && acc_addr[3:2] == 2'b01) |=> $stable(prd_base[31:0]));

  // R10: table base of channel 1 holds unless its bytes are written
  a_r10_table1_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && acc_addr[3:2] == 2'b11) |=> $stable(prd_base[63:32]));
endmodule

bind busmaster_regs bmr_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_wr      (acc_wr),
  .acc_addr    (acc_addr),
  .acc_size    (acc_size),
  .ch_irq_in   (ch_irq_in),
  .pci_irq     (pci_irq),
  .mask_q      (mask_q),
  .timing_flat (timing_flat),
  .dma_start   (dma_start),
  .prd_base    (prd_base),
  .ctl_wide_wr (ctl_wide_wr)
);

// File: tb/test_busmaster_regs.sv
`timescale 1ns/1ps
module test_busmaster_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [1:0]  ch_irq_in = '0;
  logic [1:0]  ch_dma_active = '0;
  logic [1:0]  ch_err_evt = '0;
  logic [1:0]  ch_done_evt = '0;
  logic [1:0]  dma_start, dma_stop, dma_dir;
  logic [63:0] prd_base;
  logic        pci_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busmaster_regs i_busmaster_regs (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .ch_irq_in(ch_irq_in), .ch_dma_active(ch_dma_active),
    .ch_err_evt(ch_err_evt), .ch_done_evt(ch_done_evt),
    .dma_start(dma_start), .dma_stop(dma_stop), .dma_dir(dma_dir),
    .prd_base(prd_base), .pci_irq(pci_irq)
  );

  typedef struct packed {
    logic        op;    // 1 write, 0 read-and-compare
    logic [3:0]  addr;
    logic [1:0]  size;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h3, 2'd0, 32'h0000_00A5, 8'd8},   // R8 timing ch0
    '{1'b1, 4'hB, 2'd0, 32'h0000_003C, 8'd8},   // R8 timing ch1
    '{1'b0, 4'h3, 2'd0, 32'h0000_00A5, 8'd8},
    '{1'b0, 4'hB, 2'd0, 32'h0000_003C, 8'd8},
    '{1'b1, 4'h3, 2'd1, 32'h0000_FFFF, 8'd2},   // R2 wide write dropped
    '{1'b0, 4'h3, 2'd0, 32'h0000_00A5, 8'd2},
    '{1'b0, 4'h2, 2'd1, 32'h0000_FFFF, 8'd2},   // R2 wide reads
    '{1'b0, 4'h0, 2'd2, 32'hFFFF_FFFF, 8'd2},
    '{1'b1, 4'h4, 2'd2, 32'h1234_5677, 8'd10},  // R10 dword, low bits forced
    '{1'b0, 4'h4, 2'd2, 32'h1234_5674, 8'd10},
    '{1'b1, 4'hE, 2'd1, 32'h0000_BEEF, 8'd10},  // R10 word into lanes 2,3
    '{1'b0, 4'hC, 2'd2, 32'hBEEF_0000, 8'd10},
    '{1'b0, 4'hF, 2'd0, 32'h0000_00BE, 8'd10},
    '{1'b1, 4'h5, 2'd0, 32'h0000_0099, 8'd10},  // R10 byte lane 1
    '{1'b0, 4'h4, 2'd2, 32'h1234_9974, 8'd10},
    '{1'b0, 4'h6, 2'd1, 32'h0000_1234, 8'd10},
    '{1'b1, 4'h1, 2'd0, 32'h0000_00FF, 8'd4},   // R4 only mask bits land
    '{1'b0, 4'h9, 2'd0, 32'h0000_0030, 8'd11},  // R11 shared view
    '{1'b0, 4'h1, 2'd0, 32'h0000_0030, 8'd11},
    '{1'b1, 4'h2, 2'd0, 32'h0000_00FF, 8'd6},   // R6 status write
    '{1'b0, 4'h2, 2'd0, 32'h0000_0060, 8'd6},
    '{1'b0, 4'hA, 2'd0, 32'h0000_0000, 8'd6},
    '{1'b1, 4'hA, 2'd1, 32'h0000_FFFF, 8'd2},   // R2 wide status write dropped
    '{1'b0, 4'hA, 2'd0, 32'h0000_0000, 8'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    acc_addr = a; acc_size = s;
    #1;
    d = acc_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h3, 2'd0, r); chk("R1 timing0", r, 0);
    rd(4'h1, 2'd0, r); chk("R1 mode", r, 0);
    chk("R1 prd_base", prd_base[31:0] | prd_base[63:32], 0);
    chk("R1 irq/start/stop/dir", {pci_irq, dma_start, dma_stop, dma_dir}, 0);

    // R3 map exercised by the vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op) wr(VEC[i].addr, VEC[i].size, VEC[i].data);
      else begin
        rd(VEC[i].addr, VEC[i].size, r);
        chk($sformatf("vec %0d R%0d (R3 map)", i, VEC[i].req), r, VEC[i].data);
      end
    end

    // R4 / R5 interrupt combining
    wr(4'h1, 2'd0, 32'h00);
    @(negedge clk); ch_irq_in = 2'b01;
    @(negedge clk);
    chk("R5 ch0 unmasked", {31'b0, pci_irq}, 1);
    rd(4'h1, 2'd0, r); chk("R4 pending0", r, 32'h04);
    wr(4'h1, 2'd0, 32'h10);
    chk("R5 ch0 masked", {31'b0, pci_irq}, 0);
    rd(4'h9, 2'd0, r); chk("R4 mode after mask0", r, 32'h14);
    ch_irq_in = 2'b11;
    @(negedge clk);
    chk("R5 ch1 unmasked", {31'b0, pci_irq}, 1);
    wr(4'h9, 2'd0, 32'hEF);
    rd(4'h1, 2'd0, r); chk("R4 only bits 5:4 change", r, 32'h2C);
    chk("R5 ch0 live again", {31'b0, pci_irq}, 1);
    wr(4'h1, 2'd0, 32'h30);
    chk("R5 both masked", {31'b0, pci_irq}, 0);
    ch_irq_in = 2'b00;
    @(negedge clk);
    rd(4'h1, 2'd0, r); chk("R4 pending follows input", r, 32'h30);

    // R6 / R7 status
    ch_done_evt[0] = 1'b1; @(negedge clk); ch_done_evt[0] = 1'b0;
    rd(4'h2, 2'd0, r); chk("R7 done sets bit2", r, 32'h64);
    ch_err_evt[0] = 1'b1; @(negedge clk); ch_err_evt[0] = 1'b0;
    rd(4'h2, 2'd0, r); chk("R7 err sets bit1", r, 32'h66);
    wr(4'h2, 2'd0, 32'h04);
    rd(4'h2, 2'd0, r); chk("R6 w1c bit2, load 6:5", r, 32'h02);
    wr(4'h2, 2'd0, 32'h62);
    rd(4'h2, 2'd0, r); chk("R6 w1c bit1", r, 32'h60);
    ch_done_evt[0] = 1'b1; @(negedge clk); ch_done_evt[0] = 1'b0;
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = 4'h2; acc_size = 2'd0; acc_wdata = 32'h64;
    ch_done_evt[0] = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; ch_done_evt[0] = 1'b0;
    rd(4'h2, 2'd0, r); chk("R7 set beats clear", r, 32'h64);
    ch_dma_active[1] = 1'b1;
    rd(4'hA, 2'd0, r); chk("R6 active mirror ch1", r, 32'h01);
    rd(4'h2, 2'd0, r); chk("R6 ch0 unaffected", r, 32'h64);
    ch_dma_active[1] = 1'b0;

    // R9 command
    wr(4'h0, 2'd0, 32'h09);
    chk("R9 start pulse", {30'b0, dma_start}, 32'h1);
    chk("R9 dir", {30'b0, dma_dir}, 32'h1);
    rd(4'h0, 2'd0, r); chk("R9 cmd read", r, 32'h09);
    @(negedge clk);
    chk("R9 start one cycle", {30'b0, dma_start}, 0);
    wr(4'h0, 2'd0, 32'hF7);
    chk("R9 no start when run stays", {28'b0, dma_start, dma_stop}, 0);
    rd(4'h0, 2'd0, r); chk("R9 cmd bits 0,3 only", r, 32'h01);
    wr(4'h0, 2'd0, 32'h00);
    chk("R9 stop pulse", {30'b0, dma_stop}, 32'h1);
    wr(4'h8, 2'd0, 32'hFF);
    chk("R9 ch1 start", {30'b0, dma_start}, 32'h2);
    chk("R9 ch1 dir", {30'b0, dma_dir}, 32'h2);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(4'hB, 2'd0, r); chk("R1 timing1 after reset", r, 0);
    rd(4'h8, 2'd0, r); chk("R1 cmd1 after reset", r, 0);
    chk("R1 prd after reset", prd_base[31:0] | prd_base[63:32], 0);
    chk("R1 dir after reset", {30'b0, dma_dir}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule